// File: doc/BRIEF.md
# Masked-Snapshot Sticky Status Bank

This block collects event and alarm inputs that arrive with no relation to the system clock. Each input passes through a two-flop synchronizer, and the synchronized level sets a sticky bit in one of three latched registers. Two of these registers are status registers and one holds receive information. A fourth register is not sticky. It shows the synchronized live state of an external synchronizer and is read-only.

Software reaches the bank through a byte-wide parallel port with single-cycle strobes. A read of a latched register never returns the live sticky bits. Instead, the host first writes a mask byte to that address. For every mask bit at 1, the current sticky value is copied into a read-holding register and the sticky bit is cleared. Mask bits at 0 leave both the holding register and the sticky bit unchanged. The host then reads the holding register and writes back (value AND mask). This second write clears any bit that was set again during the access.

The two status registers each drive an active-low interrupt output. Each bit of a status register can be enabled toward its interrupt through its own enable register.

Top module: `status_snap_bank`

## Requirements
- R1: Address map on `addr_i`: 0 is status A, 1 is status B, 2 is receive info, 3 is live sync status, 4 is the interrupt enable for A, 5 is the interrupt enable for B. Addresses 6 and 7 read as 0x00. The enable registers read back the value last written to them.
- R2: A sticky bit that has been set stays at 1 through any number of cycles until a mask write with that bit at 1 is made to its register.
- R3: After a sticky bit is cleared, it is set again only if its synchronized event input is still high or goes high again.
- R4: A write of mask `m` to a latched register copies the sticky bits selected by `m` into that register's holding register and clears those sticky bits.
- R5: Bits where the mask is 0 keep their previous holding value and their sticky value.
- R6: An event that is high in the same cycle as a clearing write leaves its bit set. A write-back of (value AND mask) after the event has ended leaves the holding bit at 0.
- R7: Address 3 returns the synchronized live input with no preceding write, and writes to it have no effect.
- R8: `irq_a_n_o` and `irq_b_n_o` are low exactly while a sticky bit of status A or B is 1 and the matching enable bit is 1. A 1 in an enable register enables that bit.
- R9: After the synchronous active-low reset, all sticky bits, holding registers and enable registers are 0, and both interrupt outputs are high.
- R10: A read strobe returns its data on `rdata_o` one cycle later. For addresses 0 to 2 the data is the holding register, not the live sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_a_i | input | 8 | Asynchronous events for status A |
| evt_b_i | input | 8 | Asynchronous events for status B |
| evt_info_i | input | 8 | Asynchronous receive-info events |
| sync_stat_i | input | 8 | Asynchronous live synchronizer state |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data / mask |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| irq_a_n_o | output | 1 | Active-low interrupt from status A |
| irq_b_n_o | output | 1 | Active-low interrupt from status B |

## Verification
The assertions check every cycle that the sticky bits only fall under a write to their own address. They also check that a mask write copies exactly the selected bits into the holding register and leaves the other bits alone, that an idle port leaves the holding registers unchanged, and that an event coinciding with a clear keeps its bit set. What only the bench's scenarios can show is the full host procedure of mask write, read and write-back at the ports. Those scenarios also cover a persistent alarm that sets its bit again, the latency through the synchronizers, the per-bit interrupt enables, and the read-only behaviour of the live register.

// File: rtl/stsnap_pkg.sv
package stsnap_pkg;
    // Data width of the host port and of every register.
    parameter int DW   = 8;
    // Address width of the host port.
    parameter int AW   = 3;
    // Number of sticky registers (status A, status B, receive info).
    parameter int NLAT = 3;
    // Number of sticky registers that drive an interrupt.
    parameter int NIRQ = 2;

    localparam logic [AW-1:0] ADR_STAT_A = AW'(0);
    localparam logic [AW-1:0] ADR_STAT_B = AW'(1);
    localparam logic [AW-1:0] ADR_INFO   = AW'(2);
    localparam logic [AW-1:0] ADR_SYNC   = AW'(3);
    localparam logic [AW-1:0] ADR_IEN_A  = AW'(4);
    localparam logic [AW-1:0] ADR_IEN_B  = AW'(5);

    typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/stsnap_sync.sv
// Two-flop synchronizer, one per bit of a W-wide asynchronous bus.
// Assumes each input bit is stable for long enough to be seen; the bits
// are not treated as a coherent word.
module stsnap_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Purpose: move the bus into the clock domain through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/stsnap_latch.sv
// One sticky register with its read-holding register.
// Assumes evt_i is already synchronized. A clearing write (clr_en) with
// mask_i copies the selected sticky bits to the holding register and clears
// them; an event that is high in the same cycle wins over the clear.
module stsnap_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_en,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] lat_o,
    output logic [W-1:0] hold_o
);
    logic [W-1:0] clr_bits;

    // Purpose: select the bits that this cycle's write clears.
    always_comb begin
        clr_bits = clr_en ? mask_i : '0;
    end

    // Purpose: keep the sticky bits and update the masked snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_o  <= '0;
            hold_o <= '0;
        end else begin
            lat_o <= (lat_o & ~clr_bits) | evt_i;
            if (clr_en) begin
                hold_o <= (hold_o & ~mask_i) | (lat_o & mask_i);
            end
        end
    end
endmodule

// File: rtl/stsnap_irq.sv
// Active-low interrupt from a sticky register and its per-bit enable.
// Assumes a 1 in en_i enables the bit. The output is combinational from flops.
module stsnap_irq #(
    parameter int W = 8
) (
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] en_i,
    output logic         irq_n_o
);
    // Purpose: pull the line low while any enabled bit is set.
    always_comb begin
        irq_n_o = ~(|(lat_i & en_i));
    end
endmodule

// File: rtl/status_snap_bank.sv
// Bank of three sticky registers, one live status register and two
// interrupt-enable registers behind a byte-wide host port.
// Assumes single-cycle wr_i/rd_i strobes and that rdata_o is taken one
// cycle after rd_i.
module status_snap_bank
    import stsnap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_a_i,
    input  logic [DW-1:0] evt_b_i,
    input  logic [DW-1:0] evt_info_i,
    input  logic [DW-1:0] sync_stat_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wr_i,
    input  logic          rd_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_a_n_o,
    output logic          irq_b_n_o
);
    byte_t           evt_raw [NLAT];
    byte_t           evt_s   [NLAT];
    byte_t           lat_vec [NLAT];
    byte_t           hold_vec[NLAT];
    byte_t           ien_q   [NIRQ];
    logic [NIRQ-1:0] irq_n;
    logic [NLAT-1:0] wr_sel;
    byte_t           sync_live;
    byte_t           rd_mux;

    // Purpose: gather the event buses into an indexable array.
    always_comb begin
        evt_raw[0] = evt_a_i;
        evt_raw[1] = evt_b_i;
        evt_raw[2] = evt_info_i;
    end

    generate
        for (genvar i = 0; i < NLAT; i++) begin : g_lat
            // Purpose: decode a write to sticky register i.
            always_comb begin
                wr_sel[i] = wr_i && (addr_i == AW'(i));
            end

            stsnap_sync #(.W(DW)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .async_i(evt_raw[i]),
                .sync_o (evt_s[i])
            );

            stsnap_latch #(.W(DW)) u_latch (
                .clk   (clk),
                .rst_n (rst_n),
                .evt_i (evt_s[i]),
                .clr_en(wr_sel[i]),
                .mask_i(wdata_i),
                .lat_o (lat_vec[i]),
                .hold_o(hold_vec[i])
            );
        end

        for (genvar j = 0; j < NIRQ; j++) begin : g_irq
            // Purpose: hold the interrupt enable register for source j.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ien_q[j] <= '0;
                end else if (wr_i && addr_i == ADR_IEN_A + AW'(j)) begin
                    ien_q[j] <= wdata_i;
                end
            end

            stsnap_irq #(.W(DW)) u_irq (
                .lat_i  (lat_vec[j]),
                .en_i   (ien_q[j]),
                .irq_n_o(irq_n[j])
            );
        end
    endgenerate

    stsnap_sync #(.W(DW)) u_sync_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(sync_stat_i),
        .sync_o (sync_live)
    );

    // Purpose: select the read source by address.
    always_comb begin
        case (addr_i)
            ADR_STAT_A: rd_mux = hold_vec[0];
            ADR_STAT_B: rd_mux = hold_vec[1];
            ADR_INFO:   rd_mux = hold_vec[2];
            ADR_SYNC:   rd_mux = sync_live;
            ADR_IEN_A:  rd_mux = ien_q[0];
            ADR_IEN_B:  rd_mux = ien_q[1];
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= rd_mux;
        end
    end

    assign irq_a_n_o = irq_n[0];
    assign irq_b_n_o = irq_n[1];
endmodule

// File: rtl/stsnap_chk.sv
// Assertion checker for status_snap_bank, attached by bind below.
module stsnap_chk
    import stsnap_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic [DW-1:0] wdata_i,
    input logic          wr_i,
    input logic [DW-1:0] lat_a,
    input logic [DW-1:0] hold_a,
    input logic [DW-1:0] evs_a,
    input logic [DW-1:0] lat_b,
    input logic [DW-1:0] en_b,
    input logic          irq_b_n_o
);
    // R2: without a write to status A no sticky bit falls
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADR_STAT_A) |=> ((lat_a & $past(lat_a)) == $past(lat_a)));

    // R4: selected bits of the holding register take the sticky value
    p_snap_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_STAT_A) |=> ((hold_a & $past(wdata_i)) == ($past(lat_a) & $past(wdata_i))));

    // R5: unselected holding bits are unchanged by a mask write
    p_snap_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_STAT_A) |=> ((hold_a & ~$past(wdata_i)) == ($past(hold_a) & ~$past(wdata_i))));

    // R10: no write to status A leaves its holding register stable
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADR_STAT_A) |=> $stable(hold_a));

    // R6: an event in the clearing cycle keeps its bit set
    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_STAT_A) |=> ((lat_a & $past(evs_a)) == $past(evs_a)));

    // R8: with no enabled bit set the interrupt line is high
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_b & en_b) == '0) |-> irq_b_n_o);
endmodule

bind status_snap_bank stsnap_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .lat_a    (lat_vec[0]),
    .hold_a   (hold_vec[0]),
    .evs_a    (evt_s[0]),
    .lat_b    (lat_vec[1]),
    .en_b     (ien_q[1]),
    .irq_b_n_o(irq_b_n_o)
);

// File: tb/sim_status_snap_bank.sv
`timescale 1ns/1ps
module sim_status_snap_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_a_i = '0, evt_b_i = '0, evt_info_i = '0, sync_stat_i = '0;
    logic [2:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_i = 1'b0, rd_i = 1'b0;
    logic [7:0] rdata_o;
    logic       irq_a_n_o, irq_b_n_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_q = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    status_snap_bank u0 (
        .clk(clk), .rst_n(rst_n), .evt_a_i(evt_a_i), .evt_b_i(evt_b_i),
        .evt_info_i(evt_info_i), .sync_stat_i(sync_stat_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
        .irq_a_n_o(irq_a_n_o), .irq_b_n_o(irq_b_n_o)
    );

    // Monitor: a read strobe seen at an edge yields data compared at the next falling edge.
    always @(posedge clk) rd_q <= rd_i;

    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata_o !== e) begin
                errors++;
                $display("FAIL %s rdata actual %02h expected %02h", t, rdata_o, e);
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", t, act, e);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R9 reset state
        rd(3'd0, 8'h00, "R9");
        rd(3'd4, 8'h00, "R9");
        chk_bit(irq_a_n_o, 1'b1, "R9");
        chk_bit(irq_b_n_o, 1'b1, "R9");

        // R10: sticky bit set, holding register still 0
        evt_a_i = 8'h01; idle(1); evt_a_i = 8'h00; idle(4);
        rd(3'd0, 8'h00, "R10");
        wr(3'd4, 8'h01);
        chk_bit(irq_a_n_o, 1'b0, "R8");
        rd(3'd4, 8'h01, "R1");
        // R4 snapshot and clear, then write-back
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h01, "R4");
        chk_bit(irq_a_n_o, 1'b1, "R8");
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h00, "R3");

        // R5 per-bit polling
        evt_a_i = 8'h06; idle(1); evt_a_i = 8'h00; idle(4);
        chk_bit(irq_a_n_o, 1'b1, "R8");
        wr(3'd0, 8'h02);
        rd(3'd0, 8'h02, "R4");
        wr(3'd0, 8'h04);
        rd(3'd0, 8'h06, "R5");
        wr(3'd0, 8'h02);
        rd(3'd0, 8'h04, "R5");

        // R6 persistent alarm on status B
        evt_b_i = 8'h08; idle(4);
        wr(3'd1, 8'h08);
        rd(3'd1, 8'h08, "R6");
        wr(3'd1, 8'h08);
        rd(3'd1, 8'h08, "R3");
        evt_b_i = 8'h00; idle(4);
        wr(3'd1, 8'h08);
        wr(3'd1, 8'h08);
        rd(3'd1, 8'h00, "R6");

        // R2 sticky across a long idle
        evt_info_i = 8'h80; idle(1); evt_info_i = 8'h00; idle(20);
        wr(3'd2, 8'h80);
        rd(3'd2, 8'h80, "R2");

        // R7 live register
        sync_stat_i = 8'hA5; idle(3);
        rd(3'd3, 8'hA5, "R7");
        sync_stat_i = 8'h3C; idle(3);
        rd(3'd3, 8'h3C, "R7");
        wr(3'd3, 8'hFF);
        rd(3'd3, 8'h3C, "R7");

        // R8 per-bit enables on status B
        wr(3'd5, 8'h10);
        evt_b_i = 8'h20; idle(1); evt_b_i = 8'h00; idle(4);
        chk_bit(irq_b_n_o, 1'b1, "R8");
        evt_b_i = 8'h10; idle(1); evt_b_i = 8'h00; idle(4);
        chk_bit(irq_b_n_o, 1'b0, "R8");
        chk_bit(irq_a_n_o, 1'b1, "R8");
        rd(3'd5, 8'h10, "R1");
        rd(3'd6, 8'h00, "R1");

        idle(2);
        done = 1'b1;
        summary();
    end
endmodule